// File: doc/BRIEF.md
# Segmented Backplane Address Window Bridge

This block connects a host-side card interface to a 32-bit internal backplane. The host side has two parts. The first is a narrow byte-wide configuration port. The second is a 16-bit memory window that spans 2 KB of host offsets.

Three configuration registers hold the upper part of a backplane base address:
- a nibble for bits 15:12;
- a byte for bits 23:16;
- a byte for bits 31:24.

A one-bit segment register picks which 2 KB half of a 4 KB core region the window reaches. Software that needs offset 0x800 or above of a core selects segment 1 and issues the offset less 0x800. Every configuration register reads back, so software can confirm a switch before it uses the window.

Each host access inside the window becomes one registered backplane request. The backplane address is the base, then the segment bit, then the 11-bit window offset. Byte and halfword accesses map straight onto the backplane byte lanes.

A full 32-bit write arrives as two halfword writes, low half first:
- The low half is staged and causes no backplane access.
- The high half commits a single 32-bit write.

A full 32-bit read is simply two halfword reads. An option register must have its function-enable bit set and its soft-reset bit clear before the window responds. While the window is closed, writes are dropped and reads return all ones.

Top module: `seg_window_bridge`

## Requirements
- R1: The config register at offset 0x2E stores backplane address bits 15:12 from write data bits 3:0. Reading it returns those four bits in bits 3:0, and bits 7:4 always read 0.
- R2: The register at 0x30 (address bits 23:16) and the one at 0x32 (bits 31:24) read back the full byte written. The segment register at 0x34 stores write bit 0 only and reads back as 0 or 1.
- R3: A backplane request appears on `bp_valid` one cycle after the host request is sampled. Its address is {reg 0x32, reg 0x30, reg 0x2E[3:0], segment, h_off[10:0]}, so backplane bit 11 equals the segment bit.
- R4: After reset every config register reads 0, the window is closed, and no backplane request is issued.
- R5: The option register at 0x00 keeps only bit 7 (soft reset), bit 6 (level-mode interrupt), bit 2 (interrupt enable) and bit 0 (function enable); all other bits read 0. The window is open only when bit 0 is 1 and bit 7 is 0.
- R6: While the window is closed, host writes cause no backplane request, and host reads complete two cycles later with data 0xFFFF.
- R7: Byte access (h_size 0):
  - Write byte enable is one-hot at bit h_off[1:0], and the write byte is copied to all four lanes.
  - Read data is the addressed lane in bits 7:0, with bits 15:8 zero.
- R8: Halfword access (h_size 1):
  - Byte enable is 4'b0011 when h_off[1] is 0 and 4'b1100 when it is 1.
  - Write data is copied to both halves, and a read returns the half selected by h_off[1].
- R9: Word-pair writes:
  - A word-low write (h_size 2) stages its data and causes no backplane request.
  - A following word-high write (h_size 3) commits one write with byte enable 4'b1111, data {high, low}, and address bits 1:0 cleared.
- R10: A word-high write with no staged low half causes no backplane request.
- R11: Reads with h_size 2 or 3 behave exactly as halfword reads.
- R12: For a backplane read, `h_rvalid` pulses and `h_rdata` is valid one cycle after the backplane request, two cycles after the host request.
- R13: Reads of config offsets other than 0x00, 0x2E, 0x30, 0x32 and 0x34 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 8 | Config register offset |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data for cfg_addr (combinational) |
| h_req | input | 1 | Host window access request, one cycle |
| h_we | input | 1 | Host access is a write |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word low half, 3 word high half |
| h_off | input | 11 | Byte offset within the 2 KB window |
| h_wdata | input | 16 | Host write data |
| h_rvalid | output | 1 | Host read data valid pulse |
| h_rdata | output | 16 | Host read data |
| bp_valid | output | 1 | Backplane request pulse |
| bp_we | output | 1 | Backplane request is a write |
| bp_addr | output | 32 | Backplane byte address |
| bp_be | output | 4 | Backplane byte enables |
| bp_wdata | output | 32 | Backplane write data |
| bp_rdata | input | 32 | Backplane read data, valid while bp_valid is high |

## Verification
Results fall due at three different delays:
- Config readback is combinational and is checked one time step after the offset settles.
- The backplane request fields are due one edge after the host request.
- Read return data is due two edges after the host request.

The bench drives every input on a falling edge, holds the request for one cycle, and samples the backplane fields at the next falling edge and the read return at the one after. A config write affects the first host request sampled after its own edge, so the bench finishes each register write before it issues the window access that depends on it.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int OFF_W  = 11;
  localparam int NIB_W  = 16 - OFF_W - 1;
  localparam int BYTE_W = 8;
  localparam int HD_W   = 2 * BYTE_W;
  localparam int BP_DW  = 2 * HD_W;
  localparam int BP_AW  = 2 * BYTE_W + NIB_W + 1 + OFF_W;
  localparam int LANES  = BP_DW / BYTE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WLO  = 2'd2,
    SZ_WHI  = 2'd3
  } xsz_e;

  function automatic logic [BP_AW-1:0] mk_addr(
    input logic [BYTE_W-1:0] hi, input logic [BYTE_W-1:0] mid,
    input logic [NIB_W-1:0] nib, input logic seg, input logic [OFF_W-1:0] off);
    return {hi, mid, nib, seg, off};
  endfunction

  function automatic logic [LANES-1:0] lane_be(input xsz_e sz, input logic [1:0] lo);
    if (sz == SZ_BYTE) return LANES'(1) << lo;
    return lo[1] ? 4'b1100 : 4'b0011;
  endfunction

  function automatic logic [BP_DW-1:0] spread(input xsz_e sz, input logic [HD_W-1:0] wd);
    if (sz == SZ_BYTE) return {LANES{wd[BYTE_W-1:0]}};
    return {2{wd}};
  endfunction

  function automatic logic [HD_W-1:0] pick(input logic is_byte, input logic [1:0] lo,
                                           input logic [BP_DW-1:0] rd);
    logic [BYTE_W-1:0] b;
    case (lo)
      2'd0: b = rd[7:0];
      2'd1: b = rd[15:8];
      2'd2: b = rd[23:16];
      default: b = rd[31:24];
    endcase
    if (is_byte) return {{BYTE_W{1'b0}}, b};
    return lo[1] ? rd[31:16] : rd[15:0];
  endfunction
endpackage

// File: rtl/bw_cfg_regs.sv
module bw_cfg_regs
  import bw_pkg::*;
#(
  parameter logic [7:0] OPT_OFS = 8'h00,
  parameter logic [7:0] NIB_OFS = 8'h2E,
  parameter logic [7:0] MID_OFS = 8'h30,
  parameter logic [7:0] HI_OFS  = 8'h32,
  parameter logic [7:0] SEG_OFS = 8'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic [7:0]        base_hi,
  output logic [7:0]        base_mid,
  output logic [NIB_W-1:0]  base_nib,
  output logic              seg,
  output logic              win_en
);
  localparam logic [7:0] OPT_MASK = 8'hC5;
  localparam int OPT_SRST = 7;
  localparam int OPT_FEN  = 0;

  logic [7:0] opt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q    <= '0;
      base_nib <= '0;
      base_mid <= '0;
      base_hi  <= '0;
      seg      <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        OPT_OFS: opt_q    <= cfg_wdata & OPT_MASK;
        NIB_OFS: base_nib <= cfg_wdata[NIB_W-1:0];
        MID_OFS: base_mid <= cfg_wdata;
        HI_OFS:  base_hi  <= cfg_wdata;
        SEG_OFS: seg      <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      OPT_OFS: cfg_rdata = opt_q;
      NIB_OFS: cfg_rdata = 8'(base_nib);
      MID_OFS: cfg_rdata = base_mid;
      HI_OFS:  cfg_rdata = base_hi;
      SEG_OFS: cfg_rdata = {7'd0, seg};
      default: cfg_rdata = 8'd0;
    endcase
  end

  assign win_en = opt_q[OPT_FEN] & ~opt_q[OPT_SRST];
endmodule

// File: rtl/bw_stage.sv
module bw_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         take,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (load) begin
      full <= 1'b1;
      dout <= din;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/bw_xfer.sv
module bw_xfer
  import bw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  xsz_e              sz,
  input  logic [OFF_W-1:0]  h_off,
  input  logic [HD_W-1:0]   h_wdata,
  input  logic              win_en,
  input  logic [7:0]        base_hi,
  input  logic [7:0]        base_mid,
  input  logic [NIB_W-1:0]  base_nib,
  input  logic              seg,
  input  logic              stage_full,
  input  logic [HD_W-1:0]   stage_data,
  output logic              stage_load,
  output logic              stage_take,
  output logic              bp_valid,
  output logic              bp_we,
  output logic [BP_AW-1:0]  bp_addr,
  output logic [LANES-1:0]  bp_be,
  output logic [BP_DW-1:0]  bp_wdata,
  input  logic [BP_DW-1:0]  bp_rdata,
  output logic              h_rvalid,
  output logic [HD_W-1:0]   h_rdata
);
  logic acc_ok, wr_lo, wr_hi, issue, refuse_rd;
  logic [OFF_W-1:0] eff_off;
  logic rd_live, rd_byte, rd_refused;

  assign acc_ok     = h_req && win_en;
  assign wr_lo      = acc_ok && h_we && (sz == SZ_WLO);
  assign wr_hi      = acc_ok && h_we && (sz == SZ_WHI);
  assign stage_load = wr_lo;
  assign stage_take = wr_hi && stage_full;
  assign issue      = acc_ok && !wr_lo && !(wr_hi && !stage_full);
  assign refuse_rd  = h_req && !h_we && !win_en;
  assign eff_off    = stage_take ? {h_off[OFF_W-1:2], 2'b00} : h_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_valid   <= 1'b0;
      bp_we      <= 1'b0;
      bp_addr    <= '0;
      bp_be      <= '0;
      bp_wdata   <= '0;
      rd_live    <= 1'b0;
      rd_byte    <= 1'b0;
      rd_refused <= 1'b0;
    end else begin
      bp_valid   <= issue;
      rd_live    <= issue && !h_we;
      rd_refused <= refuse_rd;
      if (issue) begin
        bp_we    <= h_we;
        bp_addr  <= mk_addr(base_hi, base_mid, base_nib, seg, eff_off);
        bp_be    <= stage_take ? {LANES{1'b1}} : lane_be(sz, h_off[1:0]);
        bp_wdata <= stage_take ? {h_wdata, stage_data} : spread(sz, h_wdata);
        rd_byte  <= (sz == SZ_BYTE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
    end else begin
      h_rvalid <= rd_live || rd_refused;
      if (rd_refused)   h_rdata <= {HD_W{1'b1}};
      else if (rd_live) h_rdata <= pick(rd_byte, bp_addr[1:0], bp_rdata);
    end
  end
endmodule

// File: rtl/seg_window_bridge.sv
module seg_window_bridge
  import bw_pkg::*;
#(
  parameter logic [7:0] OPT_OFS = 8'h00,
  parameter logic [7:0] NIB_OFS = 8'h2E,
  parameter logic [7:0] MID_OFS = 8'h30,
  parameter logic [7:0] HI_OFS  = 8'h32,
  parameter logic [7:0] SEG_OFS = 8'h34
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        h_req,
  input  logic        h_we,
  input  logic [1:0]  h_size,
  input  logic [10:0] h_off,
  input  logic [15:0] h_wdata,
  output logic        h_rvalid,
  output logic [15:0] h_rdata,
  output logic        bp_valid,
  output logic        bp_we,
  output logic [31:0] bp_addr,
  output logic [3:0]  bp_be,
  output logic [31:0] bp_wdata,
  input  logic [31:0] bp_rdata
);
  logic [7:0]       base_hi, base_mid;
  logic [NIB_W-1:0] base_nib;
  logic             seg, win_en;
  logic             stage_full, stage_load, stage_take;
  logic [HD_W-1:0]  stage_data;
  xsz_e             sz;

  assign sz = xsz_e'(h_size);

  bw_cfg_regs #(
    .OPT_OFS(OPT_OFS), .NIB_OFS(NIB_OFS), .MID_OFS(MID_OFS),
    .HI_OFS(HI_OFS), .SEG_OFS(SEG_OFS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .base_hi(base_hi),
    .base_mid(base_mid), .base_nib(base_nib), .seg(seg), .win_en(win_en)
  );

  bw_stage #(.W(HD_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .load(stage_load), .take(stage_take),
    .din(h_wdata), .full(stage_full), .dout(stage_data)
  );

  bw_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .sz(sz),
    .h_off(h_off), .h_wdata(h_wdata), .win_en(win_en), .base_hi(base_hi),
    .base_mid(base_mid), .base_nib(base_nib), .seg(seg),
    .stage_full(stage_full), .stage_data(stage_data),
    .stage_load(stage_load), .stage_take(stage_take),
    .bp_valid(bp_valid), .bp_we(bp_we), .bp_addr(bp_addr), .bp_be(bp_be),
    .bp_wdata(bp_wdata), .bp_rdata(bp_rdata),
    .h_rvalid(h_rvalid), .h_rdata(h_rdata)
  );
endmodule

// File: rtl/bw_checker.sv
module bw_checker #(
  parameter logic [7:0] NIB_OFS = 8'h2E
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_rdata,
  input logic        win_en,
  input logic        seg,
  input logic        stage_full,
  input logic        bp_valid,
  input logic        bp_we,
  input logic [31:0] bp_addr,
  input logic [3:0]  bp_be,
  input logic        h_rvalid
);
  AST_NIB_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == NIB_OFS) |-> (cfg_rdata[7:4] == 4'd0)); // R1

  AST_SEG_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    bp_valid |-> (bp_addr[bw_pkg::OFF_W] == $past(seg))); // R3

  AST_CLOSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_en) |-> !bp_valid); // R6

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    bp_valid |-> ($countones(bp_be) == 1 || $countones(bp_be) == 2 ||
                  $countones(bp_be) == 4)); // R7

  AST_FULLWORD_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_valid && bp_be == 4'hF) |-> (bp_we && $past(stage_full))); // R9

  AST_STAGE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_full) |-> !bp_valid); // R9

  AST_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_valid && !bp_we) |=> h_rvalid); // R12
endmodule

bind seg_window_bridge bw_checker #(.NIB_OFS(NIB_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .win_en(win_en), .seg(seg), .stage_full(stage_full), .bp_valid(bp_valid),
  .bp_we(bp_we), .bp_addr(bp_addr), .bp_be(bp_be), .h_rvalid(h_rvalid)
);

// File: tb/sim_seg_window_bridge.sv
module sim_seg_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  cfg_rdata;
  logic        h_req = 1'b0, h_we = 1'b0;
  logic [1:0]  h_size = 2'd0;
  logic [10:0] h_off = 11'd0;
  logic [15:0] h_wdata = 16'd0;
  logic        h_rvalid;
  logic [15:0] h_rdata;
  logic        bp_valid, bp_we;
  logic [31:0] bp_addr, bp_wdata, bp_rdata;
  logic [3:0]  bp_be;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  // Backplane model: read data derived from the request address
  assign bp_rdata = {~bp_addr[15:0], bp_addr[15:0] ^ 16'h5A5A};

  seg_window_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .h_req(h_req), .h_we(h_we),
    .h_size(h_size), .h_off(h_off), .h_wdata(h_wdata), .h_rvalid(h_rvalid),
    .h_rdata(h_rdata), .bp_valid(bp_valid), .bp_we(bp_we), .bp_addr(bp_addr),
    .bp_be(bp_be), .bp_wdata(bp_wdata), .bp_rdata(bp_rdata)
  );

  // {seg, we, size, off, wdata, exp_be, exp_access}
  localparam int NV = 11;
  localparam logic [35:0] TBL [0:NV-1] = '{
    {1'b0, 1'b0, 2'd0, 11'h001, 16'h0000, 4'b0010, 1'b1},
    {1'b0, 1'b1, 2'd0, 11'h003, 16'h00AB, 4'b1000, 1'b1},
    {1'b1, 1'b0, 2'd1, 11'h002, 16'h0000, 4'b1100, 1'b1},
    {1'b1, 1'b1, 2'd1, 11'h7FC, 16'hBEEF, 4'b0011, 1'b1},
    {1'b0, 1'b1, 2'd2, 11'h010, 16'h1111, 4'b0000, 1'b0},
    {1'b0, 1'b1, 2'd3, 11'h012, 16'h2222, 4'b1111, 1'b1},
    {1'b0, 1'b1, 2'd3, 11'h012, 16'h3333, 4'b0000, 1'b0},
    {1'b1, 1'b0, 2'd2, 11'h020, 16'h0000, 4'b0011, 1'b1},
    {1'b1, 1'b0, 2'd3, 11'h022, 16'h0000, 4'b1100, 1'b1},
    {1'b0, 1'b0, 2'd0, 11'h7FF, 16'h0000, 4'b1000, 1'b1},
    {1'b1, 1'b1, 2'd0, 11'h402, 16'h0077, 4'b0100, 1'b1}
  };

  localparam logic [7:0] A_HI = 8'h12, A_MID = 8'h34, A_NIB = 8'hA5;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic host(input logic we, input logic [1:0] sz, input logic [10:0] off,
                      input logic [15:0] wd, output logic v, output logic [31:0] ad,
                      output logic [3:0] be, output logic [31:0] wdo,
                      output logic rv, output logic [15:0] rd);
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_size = sz; h_off = off; h_wdata = wd;
    @(negedge clk);
    v = bp_valid; ad = bp_addr; be = bp_be; wdo = bp_wdata;
    h_req = 1'b0;
    @(negedge clk);
    rv = h_rvalid; rd = h_rdata;
  endtask

  function automatic logic [15:0] exp_read(input logic [31:0] a, input logic is_byte);
    logic [31:0] m;
    m = {~a[15:0], a[15:0] ^ 16'h5A5A};
    if (is_byte) return 16'((m >> (8 * a[1:0])) & 32'hFF);
    return a[1] ? m[31:16] : m[15:0];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic v, rv;
    logic [31:0] ad, wdo;
    logic [3:0] be;
    logic [15:0] rd;
    logic cur_seg;
    logic stage_ok;
    logic [15:0] stage_lo;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state
    cfg_read(8'h2E, r); chk("R4 nib reset", 32'(r), 32'h0);
    cfg_read(8'h30, r); chk("R4 mid reset", 32'(r), 32'h0);
    cfg_read(8'h32, r); chk("R4 hi reset", 32'(r), 32'h0);
    cfg_read(8'h34, r); chk("R4 seg reset", 32'(r), 32'h0);
    cfg_read(8'h00, r); chk("R4 opt reset", 32'(r), 32'h0);
    host(1'b0, 2'd1, 11'h004, 16'h0, v, ad, be, wdo, rv, rd);
    chk("R4 closed no access", 32'(v), 32'h0);
    chk("R6 closed read valid", 32'(rv), 32'h1);
    chk("R6 closed read ones", 32'(rd), 32'hFFFF);

    // R1, R2, R13: register readback
    cfg_write(8'h2E, A_NIB); cfg_read(8'h2E, r); chk("R1 nib readback", 32'(r), 32'h05);
    cfg_write(8'h30, A_MID); cfg_read(8'h30, r); chk("R2 mid readback", 32'(r), 32'h34);
    cfg_write(8'h32, A_HI);  cfg_read(8'h32, r); chk("R2 hi readback", 32'(r), 32'h12);
    cfg_write(8'h34, 8'hFF); cfg_read(8'h34, r); chk("R2 seg readback", 32'(r), 32'h01);
    cfg_write(8'h34, 8'h00); cfg_read(8'h34, r); chk("R2 seg clear", 32'(r), 32'h00);
    cfg_write(8'h40, 8'h99); cfg_read(8'h40, r); chk("R13 unused offset", 32'(r), 32'h00);

    // R5, R6: option register mask and gating
    cfg_write(8'h00, 8'hFF); cfg_read(8'h00, r); chk("R5 opt mask", 32'(r), 32'hC5);
    host(1'b1, 2'd1, 11'h008, 16'h1234, v, ad, be, wdo, rv, rd);
    chk("R6 soft reset blocks write", 32'(v), 32'h0);
    host(1'b0, 2'd0, 11'h009, 16'h0, v, ad, be, wdo, rv, rd);
    chk("R6 soft reset read ones", 32'(rd), 32'hFFFF);
    chk("R6 soft reset no access", 32'(v), 32'h0);
    cfg_write(8'h00, 8'h44); // function enable clear
    host(1'b1, 2'd0, 11'h00A, 16'h0055, v, ad, be, wdo, rv, rd);
    chk("R5 func enable needed", 32'(v), 32'h0);
    cfg_write(8'h00, 8'h45); cfg_read(8'h00, r); chk("R5 opt value", 32'(r), 32'h45);

    // Vector table
    cur_seg = 1'b0;
    stage_ok = 1'b0;
    stage_lo = 16'h0;
    for (int i = 0; i < NV; i++) begin
      logic t_seg, t_we, t_acc;
      logic [1:0] t_sz;
      logic [10:0] t_off, e_off;
      logic [15:0] t_wd;
      logic [3:0] t_be;
      logic [31:0] e_addr, e_wd;
      string tag;
      {t_seg, t_we, t_sz, t_off, t_wd, t_be, t_acc} = TBL[i];
      if (t_seg != cur_seg) begin
        cfg_write(8'h34, {7'd0, t_seg});
        cur_seg = t_seg;
      end
      if (t_sz == 2'd0) tag = "R7";
      else if (t_sz == 2'd1) tag = "R8";
      else if (!t_we) tag = "R11";
      else if (t_sz == 2'd2) tag = "R9";
      else tag = stage_ok ? "R9" : "R10";
      e_off = t_off;
      e_wd = (t_sz == 2'd0) ? {4{t_wd[7:0]}} : {t_wd, t_wd};
      if (t_we && t_sz == 2'd3 && stage_ok) begin
        e_off = t_off & 11'h7FC;
        e_wd = {t_wd, stage_lo};
        stage_ok = 1'b0;
      end
      if (t_we && t_sz == 2'd2) begin
        stage_ok = 1'b1;
        stage_lo = t_wd;
      end
      e_addr = (32'(A_HI) << 24) | (32'(A_MID) << 16) | (32'(A_NIB & 8'h0F) << 12) |
               (32'(t_seg) << 11) | 32'(e_off);
      host(t_we, t_sz, t_off, t_wd, v, ad, be, wdo, rv, rd);
      chk({tag, " access"}, 32'(v), 32'(t_acc));
      if (t_acc) begin
        chk("R3 address", ad, e_addr);
        chk({tag, " byte enable"}, 32'(be), 32'(t_be));
        if (t_we) chk({tag, " write data"}, wdo, e_wd);
        else begin
          chk("R12 read valid", 32'(rv), 32'h1);
          chk({tag, " read data"}, 32'(rd), 32'(exp_read(e_addr, t_sz == 2'd0)));
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule